// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It holds a state, a tag and one data word for each line of a small direct-mapped set. The policy is write-invalidate with three line states: Invalid, Shared and Modified. Core requests are loads and stores. A request that hits with enough permission completes in the same cycle. Any other request raises a bus request and completes in the cycle the bus is granted.

Every controller on the bus watches the transactions that other controllers issue. A peer read of a line held Modified makes the controller drive the intervention signal and place its dirty word on the bus. The memory takes that word as a writeback and does not answer the read. A peer read-for-ownership of such a line works the same way, except that the holder then invalidates its copy. A bus transaction is atomic and lasts one cycle. An arbiter outside the block grants the bus to one controller at a time, so every controller observes the same order of transactions.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No core request completes without a bus grant until a line is filled, and with no request present the block drives no bus request, no completion and no intervention.
- R2: A load that misses issues command code 0 (read) with the request address. It completes in the grant cycle, returns the word on bus_rdata and leaves the line Shared.
- R3: A store that misses issues command code 1 (read-exclusive). It completes in the grant cycle and leaves the line Modified holding the stored word.
- R4: A store to a Shared line issues command code 2 (invalidate) with no data fetch. It completes in the grant cycle and leaves the line Modified.
- R5: Loads to Shared or Modified lines, and stores to Modified lines, complete in the request cycle with no bus request. A load returns the line's word.
- R6: A snooped read-exclusive or invalidate that matches a Shared line makes the line Invalid, so the next local load of it misses.
- R7: A snooped read that matches a Modified line drives snp_intervene and the line's word on snp_data in that cycle, and leaves the line Shared.
- R8: A snooped read-exclusive that matches a Modified line drives snp_intervene and the line's word, and leaves the line Invalid.
- R9: A miss whose indexed line is Modified with a different tag first issues command code 3 (writeback) with the old line's address and word. The fill follows, and the request completes only with the fill.
- R10: A local hit does not complete in a cycle in which a snooped transaction targets the same line index. A request waiting for the bus re-derives its command from the line state after each snoop, so a pending invalidate becomes a read-exclusive once its Shared copy has been invalidated.
- R11: snp_intervene is never driven for a snooped read of a Shared line, for a snooped writeback, or for a snoop whose tag differs from the resident line's tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core request present, held until core_done |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | AW | Word address: upper bits tag, low bits line index |
| core_wdata | input | DW | Store data |
| core_done | output | 1 | Request completes at the coming edge |
| core_rdata | output | DW | Load result, valid with core_done |
| bus_req | output | 1 | Controller needs the bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 writeback |
| bus_addr | output | AW | Address of the issued transaction |
| bus_wdata | output | DW | Writeback word |
| bus_rdata | input | DW | Fill word from memory or from an intervening peer |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 2 | Command of the peer transaction |
| snp_addr | input | AW | Address of the peer transaction |
| snp_intervene | output | 1 | This controller supplies the data and memory stays silent |
| snp_data | output | DW | Supplied dirty word |

## Verification
A core hit and a peer snoop can land on the same line index in one cycle, and so can a waiting request and the snoop that changes its line. The bench provokes both cases by raising two cores' requests in the same cycle. In one case the first core holds the line Modified and stores to it while the second core loads it. That core's completion must stay low while it supplies the old word, and the store then follows as an invalidate. In the other case both cores store to a line they share. The core that loses arbitration must switch its pending command from invalidate to read-exclusive and receive the winner's word by intervention.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_RDX = 2'd1,
        CMD_UPG = 2'd2,
        CMD_WB  = 2'd3
    } bus_cmd_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int TAGW   = 6,
    parameter int DW     = 16,
    localparam int IDXW  = $clog2(NLINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] loc_idx,
    input  logic            loc_we,
    input  line_st_e        loc_st_i,
    input  logic [TAGW-1:0] loc_tag_i,
    input  logic [DW-1:0]   loc_data_i,
    input  logic [IDXW-1:0] snp_idx,
    input  logic            snp_we,
    input  line_st_e        snp_st_i,
    output line_st_e        loc_st_o,
    output logic [TAGW-1:0] loc_tag_o,
    output logic [DW-1:0]   loc_data_o,
    output line_st_e        snp_st_o,
    output logic [TAGW-1:0] snp_tag_o,
    output logic [DW-1:0]   snp_data_o
);
    typedef struct packed {
        line_st_e        st;
        logic [TAGW-1:0] tag;
        logic [DW-1:0]   data;
    } line_t;

    line_t lines_d [NLINES];
    line_t lines_q [NLINES];

    // Snoop and local updates never hit the same index in one cycle:
    // a granted local fill excludes a snoop, and local hits stall on a
    // same-index snoop.
    always_comb begin
        for (int i = 0; i < NLINES; i++) begin
            lines_d[i] = lines_q[i];
        end
        if (snp_we) begin
            lines_d[snp_idx].st = snp_st_i;
        end
        if (loc_we) begin
            lines_d[loc_idx].st   = loc_st_i;
            lines_d[loc_idx].tag  = loc_tag_i;
            lines_d[loc_idx].data = loc_data_i;
        end
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lines_q[g] <= '0;
            end else begin
                lines_q[g] <= lines_d[g];
            end
        end
    end

    always_comb begin
        loc_st_o   = lines_q[loc_idx].st;
        loc_tag_o  = lines_q[loc_idx].tag;
        loc_data_o = lines_q[loc_idx].data;
        snp_st_o   = lines_q[snp_idx].st;
        snp_tag_o  = lines_q[snp_idx].tag;
        snp_data_o = lines_q[snp_idx].data;
    end
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAGW = 6,
    parameter int DW   = 16
) (
    input  logic            snp_valid,
    input  bus_cmd_e        snp_cmd,
    input  logic [TAGW-1:0] snp_tag,
    input  line_st_e        line_st,
    input  logic [TAGW-1:0] line_tag,
    input  logic [DW-1:0]   line_data,
    output logic            intervene,
    output logic [DW-1:0]   supply_data,
    output logic            upd_we,
    output line_st_e        upd_st
);
    logic match;

    always_comb begin
        match       = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
        intervene   = 1'b0;
        upd_we      = 1'b0;
        upd_st      = line_st;
        supply_data = '0;
        if (match) begin
            unique case (snp_cmd)
                CMD_RD: begin
                    if (line_st == ST_M) begin
                        intervene = 1'b1;
                        upd_we    = 1'b1;
                        upd_st    = ST_S;
                    end
                end
                CMD_RDX: begin
                    intervene = (line_st == ST_M);
                    upd_we    = 1'b1;
                    upd_st    = ST_I;
                end
                CMD_UPG: begin
                    upd_we = 1'b1;
                    upd_st = ST_I;
                end
                CMD_WB: begin
                    upd_we = 1'b0;
                end
                default: begin
                    upd_we = 1'b0;
                end
            endcase
        end
        if (intervene) begin
            supply_data = line_data;
        end
    end
endmodule

// File: rtl/msi_req_unit.sv
module msi_req_unit
    import msi_pkg::*;
#(
    parameter int AW   = 8,
    parameter int IDXW = 2,
    parameter int DW   = 16,
    localparam int TAGW = AW - IDXW
) (
    input  logic            core_req,
    input  logic            core_we,
    input  logic [AW-1:0]   core_addr,
    input  logic [DW-1:0]   core_wdata,
    input  logic            snp_valid,
    input  logic [IDXW-1:0] snp_idx,
    input  line_st_e        line_st,
    input  logic [TAGW-1:0] line_tag,
    input  logic [DW-1:0]   line_data,
    input  logic            bus_gnt,
    input  logic [DW-1:0]   bus_rdata,
    output logic            core_done,
    output logic [DW-1:0]   core_rdata,
    output logic            bus_req,
    output bus_cmd_e        bus_cmd,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    output logic            upd_we,
    output line_st_e        upd_st,
    output logic [TAGW-1:0] upd_tag,
    output logic [DW-1:0]   upd_data
);
    logic [TAGW-1:0] req_tag;
    logic [IDXW-1:0] req_idx;
    logic            hit;
    logic            stall;

    always_comb begin
        req_tag    = core_addr[AW-1:IDXW];
        req_idx    = core_addr[IDXW-1:0];
        hit        = (line_st != ST_I) && (line_tag == req_tag);
        stall      = snp_valid && (snp_idx == req_idx);
        core_done  = 1'b0;
        core_rdata = '0;
        bus_req    = 1'b0;
        bus_cmd    = CMD_RD;
        bus_addr   = core_addr;
        bus_wdata  = '0;
        upd_we     = 1'b0;
        upd_st     = line_st;
        upd_tag    = line_tag;
        upd_data   = line_data;
        if (core_req) begin
            if (hit && !(core_we && line_st == ST_S)) begin
                // permission already held: complete locally unless snooped
                if (!stall) begin
                    core_done  = 1'b1;
                    core_rdata = line_data;
                    if (core_we) begin
                        upd_we   = 1'b1;
                        upd_st   = ST_M;
                        upd_data = core_wdata;
                    end
                end
            end else if (hit) begin
                bus_req = 1'b1;
                bus_cmd = CMD_UPG;
                if (bus_gnt) begin
                    core_done  = 1'b1;
                    core_rdata = core_wdata;
                    upd_we     = 1'b1;
                    upd_st     = ST_M;
                    upd_data   = core_wdata;
                end
            end else if (line_st == ST_M) begin
                // dirty victim with another tag: write it back first
                bus_req   = 1'b1;
                bus_cmd   = CMD_WB;
                bus_addr  = {line_tag, req_idx};
                bus_wdata = line_data;
                if (bus_gnt) begin
                    upd_we = 1'b1;
                    upd_st = ST_I;
                end
            end else begin
                bus_req = 1'b1;
                bus_cmd = core_we ? CMD_RDX : CMD_RD;
                if (bus_gnt) begin
                    core_done  = 1'b1;
                    core_rdata = core_we ? core_wdata : bus_rdata;
                    upd_we     = 1'b1;
                    upd_st     = core_we ? ST_M : ST_S;
                    upd_tag    = req_tag;
                    upd_data   = core_we ? core_wdata : bus_rdata;
                end
            end
        end
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int NLINES = 4,
    localparam int IDXW  = $clog2(NLINES),
    localparam int TAGW  = AW - IDXW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_intervene,
    output logic [DW-1:0] snp_data
);
    line_st_e        loc_st, snp_st, loc_upd_st, snp_upd_st;
    logic [TAGW-1:0] loc_tag, snp_tag, loc_upd_tag;
    logic [DW-1:0]   loc_data, snp_line_data, loc_upd_data;
    logic            loc_upd_we, snp_upd_we;
    bus_cmd_e        req_cmd;

    assign bus_cmd = req_cmd;

    msi_line_store #(.NLINES(NLINES), .TAGW(TAGW), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_idx    (core_addr[IDXW-1:0]),
        .loc_we     (loc_upd_we),
        .loc_st_i   (loc_upd_st),
        .loc_tag_i  (loc_upd_tag),
        .loc_data_i (loc_upd_data),
        .snp_idx    (snp_addr[IDXW-1:0]),
        .snp_we     (snp_upd_we),
        .snp_st_i   (snp_upd_st),
        .loc_st_o   (loc_st),
        .loc_tag_o  (loc_tag),
        .loc_data_o (loc_data),
        .snp_st_o   (snp_st),
        .snp_tag_o  (snp_tag),
        .snp_data_o (snp_line_data)
    );

    msi_snoop_unit #(.TAGW(TAGW), .DW(DW)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_cmd     (bus_cmd_e'(snp_cmd)),
        .snp_tag     (snp_addr[AW-1:IDXW]),
        .line_st     (snp_st),
        .line_tag    (snp_tag),
        .line_data   (snp_line_data),
        .intervene   (snp_intervene),
        .supply_data (snp_data),
        .upd_we      (snp_upd_we),
        .upd_st      (snp_upd_st)
    );

    msi_req_unit #(.AW(AW), .IDXW(IDXW), .DW(DW)) u_req (
        .core_req   (core_req),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .snp_valid  (snp_valid),
        .snp_idx    (snp_addr[IDXW-1:0]),
        .line_st    (loc_st),
        .line_tag   (loc_tag),
        .line_data  (loc_data),
        .bus_gnt    (bus_gnt),
        .bus_rdata  (bus_rdata),
        .core_done  (core_done),
        .core_rdata (core_rdata),
        .bus_req    (bus_req),
        .bus_cmd    (req_cmd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .upd_we     (loc_upd_we),
        .upd_st     (loc_upd_st),
        .upd_tag    (loc_upd_tag),
        .upd_data   (loc_upd_data)
    );
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_req,
    input logic          core_we,
    input logic [AW-1:0] core_addr,
    input logic          core_done,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [1:0]    bus_cmd,
    input logic          snp_valid,
    input logic [1:0]    snp_cmd,
    input logic [AW-1:0] snp_addr,
    input logic          snp_intervene,
    input logic [DW-1:0] snp_data
);
    // R5: completion only answers a present request
    a_r5_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> core_req);

    // R2: a request waiting for the bus does not complete
    a_r2_wait_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |-> !core_done);

    // R11: intervention only answers a snooped read or read-exclusive
    a_r11_int_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        snp_intervene |-> (snp_valid && (snp_cmd == 2'd0 || snp_cmd == 2'd1)));

    // R7: after supplying a line it is no longer dirty here
    a_r7_int_once: assert property (@(posedge clk) disable iff (!rst_n)
        snp_intervene |=> !(snp_intervene && snp_addr == $past(snp_addr)));

    // R10: an unchanged request that lost arbitration keeps asking
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && $past(core_req && bus_req && !bus_gnt)
         && $stable(core_addr) && $stable(core_we)) |-> bus_req);

    // R9: a granted writeback of a victim is followed by the fill
    a_r9_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_cmd == 2'd3) |=>
            (!core_req || (bus_req && (bus_cmd == 2'd0 || bus_cmd == 2'd1))));

    logic unused_ok;
    assign unused_ok = ^snp_data;
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_req      (core_req),
    .core_we       (core_we),
    .core_addr     (core_addr),
    .core_done     (core_done),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd       (bus_cmd),
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_addr      (snp_addr),
    .snp_intervene (snp_intervene),
    .snp_data      (snp_data)
);

// File: tb/tb_msi_snoop_ctrl.sv
module tb_msi_snoop_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          creq   [2];
    logic          cwe    [2];
    logic [AW-1:0] caddr  [2];
    logic [DW-1:0] cwdata [2];
    logic          cdone  [2];
    logic [DW-1:0] crdata [2];
    logic          breq   [2];
    logic          bgnt   [2];
    logic [1:0]    bcmd   [2];
    logic [AW-1:0] baddr  [2];
    logic [DW-1:0] bwdata [2];
    logic          sval   [2];
    logic [1:0]    scmd   [2];
    logic [AW-1:0] saddr  [2];
    logic          sint   [2];
    logic [DW-1:0] sdata  [2];
    logic [DW-1:0] fill;
    logic [DW-1:0] mem    [256];
    logic [DW-1:0] shadow [256];

    int total = 0;
    int fails = 0;
    bit finished = 0;

    msi_snoop_ctrl #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .core_req(creq[0]), .core_we(cwe[0]), .core_addr(caddr[0]), .core_wdata(cwdata[0]),
        .core_done(cdone[0]), .core_rdata(crdata[0]),
        .bus_req(breq[0]), .bus_gnt(bgnt[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]),
        .bus_wdata(bwdata[0]), .bus_rdata(fill),
        .snp_valid(sval[0]), .snp_cmd(scmd[0]), .snp_addr(saddr[0]),
        .snp_intervene(sint[0]), .snp_data(sdata[0])
    );

    msi_snoop_ctrl #(.AW(AW), .DW(DW)) u_peer (
        .clk(clk), .rst_n(rst_n),
        .core_req(creq[1]), .core_we(cwe[1]), .core_addr(caddr[1]), .core_wdata(cwdata[1]),
        .core_done(cdone[1]), .core_rdata(crdata[1]),
        .bus_req(breq[1]), .bus_gnt(bgnt[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]),
        .bus_wdata(bwdata[1]), .bus_rdata(fill),
        .snp_valid(sval[1]), .snp_cmd(scmd[1]), .snp_addr(saddr[1]),
        .snp_intervene(sint[1]), .snp_data(sdata[1])
    );

    // fixed-priority arbiter and broadcast
    always_comb begin
        bgnt[0]  = breq[0];
        bgnt[1]  = breq[1] && !breq[0];
        sval[1]  = bgnt[0];
        scmd[1]  = bcmd[0];
        saddr[1] = baddr[0];
        sval[0]  = bgnt[1];
        scmd[0]  = bcmd[1];
        saddr[0] = baddr[1];
        if (bgnt[0]) fill = sint[1] ? sdata[1] : mem[baddr[0]];
        else         fill = sint[0] ? sdata[0] : mem[baddr[1]];
    end

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(a * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
        end else begin
            for (int m = 0; m < 2; m++) begin
                if (bgnt[m] && bcmd[m] == 2'd3) mem[baddr[m]] <= bwdata[m];
                if (sint[1-m] && bgnt[m]) mem[baddr[m]] <= sdata[1-m];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_name(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    // one core operation; records bus activity of the issuer
    task automatic run_op(input int who, input logic we, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                          output int ncmd, output logic [2:0] first_cmd,
                          output logic peer_int);
        bit seen;
        seen = 0;
        ncmd = 0;
        first_cmd = 3'd4;
        peer_int = 1'b0;
        rd = '0;
        @(negedge clk);
        creq[who] = 1'b1;
        cwe[who] = we;
        caddr[who] = a;
        cwdata[who] = wd;
        for (int k = 0; k < 40 && !seen; k++) begin
            #1;
            if (bgnt[who]) begin
                if (ncmd == 0) first_cmd = {1'b0, bcmd[who]};
                ncmd++;
                if (sint[1-who]) peer_int = 1'b1;
            end
            if (cdone[who]) begin
                rd = crdata[who];
                seen = 1;
            end
            @(posedge clk);
            #1;
            if (seen) creq[who] = 1'b0;
            else @(negedge clk);
        end
        if (!seen) chk("R2 completion timeout", 0, 1);
        creq[who] = 1'b0;
        if (we && seen) shadow[a] = wd;
    endtask

    typedef struct packed {
        logic           who;
        logic           we;
        logic [AW-1:0]  a;
        logic [DW-1:0]  wd;
        logic [2:0]     cmd;
        logic [1:0]     n;
        logic           pint;
        logic [3:0]     tag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h10, 16'h0000, 3'd0, 2'd1, 1'b0, 4'd1},
        '{1'b1, 1'b0, 8'h10, 16'h0000, 3'd0, 2'd1, 1'b0, 4'd11},
        '{1'b0, 1'b1, 8'h10, 16'h1111, 3'd2, 2'd1, 1'b0, 4'd4},
        '{1'b1, 1'b0, 8'h10, 16'h0000, 3'd0, 2'd1, 1'b1, 4'd7},
        '{1'b1, 1'b1, 8'h10, 16'h2222, 3'd2, 2'd1, 1'b0, 4'd4},
        '{1'b0, 1'b1, 8'h10, 16'h3333, 3'd1, 2'd1, 1'b1, 4'd8},
        '{1'b0, 1'b0, 8'h10, 16'h0000, 3'd4, 2'd0, 1'b0, 4'd5},
        '{1'b0, 1'b1, 8'h20, 16'h4444, 3'd3, 2'd2, 1'b0, 4'd9},
        '{1'b1, 1'b0, 8'h10, 16'h0000, 3'd0, 2'd1, 1'b0, 4'd11},
        '{1'b1, 1'b0, 8'h20, 16'h0000, 3'd0, 2'd1, 1'b1, 4'd7},
        '{1'b0, 1'b0, 8'h20, 16'h0000, 3'd4, 2'd0, 1'b0, 4'd5},
        '{1'b1, 1'b1, 8'h11, 16'h5555, 3'd1, 2'd1, 1'b0, 4'd3},
        '{1'b0, 1'b0, 8'h11, 16'h0000, 3'd0, 2'd1, 1'b1, 4'd7},
        '{1'b0, 1'b1, 8'h11, 16'h6666, 3'd2, 2'd1, 1'b0, 4'd4},
        '{1'b1, 1'b0, 8'h11, 16'h0000, 3'd0, 2'd1, 1'b1, 4'd6},
        '{1'b1, 1'b1, 8'h11, 16'h7777, 3'd2, 2'd1, 1'b0, 4'd4},
        '{1'b1, 1'b1, 8'h11, 16'h7878, 3'd4, 2'd0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 8'h11, 16'h0000, 3'd4, 2'd0, 1'b0, 4'd5},
        '{1'b0, 1'b0, 8'h11, 16'h0000, 3'd0, 2'd1, 1'b1, 4'd6}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        int n;
        logic [2:0] c;
        logic pi;
        string t;
        for (int i = 0; i < 2; i++) begin
            creq[i] = 1'b0; cwe[i] = 1'b0; caddr[i] = '0; cwdata[i] = '0;
        end
        for (int i = 0; i < 256; i++) shadow[i] = init_word(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 reset done", {31'd0, cdone[0]}, 0);
        chk("R1 reset bus_req", {31'd0, breq[0]}, 0);
        chk("R1 reset intervene", {31'd0, sint[0]}, 0);

        for (int v = 0; v < NV; v++) begin
            t = tag_name(VECS[v].tag);
            run_op(int'(VECS[v].who), VECS[v].we, VECS[v].a, VECS[v].wd, rd, n, c, pi);
            chk($sformatf("%s vec%0d cmd", t, v), {29'd0, c}, {29'd0, VECS[v].cmd});
            chk($sformatf("%s vec%0d ncmd", t, v), n, {30'd0, VECS[v].n});
            chk($sformatf("%s vec%0d intervene", t, v), {31'd0, pi}, {31'd0, VECS[v].pint});
            if (!VECS[v].we)
                chk($sformatf("%s vec%0d data", t, v), {16'd0, rd}, {16'd0, shadow[VECS[v].a]});
        end

        // R10: core hit and peer snoop on the same index in one cycle
        run_op(0, 1'b1, 8'h13, 16'hAAAA, rd, n, c, pi);
        chk("R3 setup write miss", {29'd0, c}, 32'd1);
        @(negedge clk);
        creq[0] = 1'b1; cwe[0] = 1'b1; caddr[0] = 8'h13; cwdata[0] = 16'hBBBB;
        creq[1] = 1'b1; cwe[1] = 1'b0; caddr[1] = 8'h13;
        #1;
        chk("R10 hit held off by snoop", {31'd0, cdone[0]}, 0);
        chk("R10 peer read granted", {31'd0, bgnt[1]}, 1);
        chk("R7 intervene on read", {31'd0, sint[0]}, 1);
        chk("R7 old word supplied", {16'd0, crdata[1]}, 32'hAAAA);
        chk("R7 peer completes", {31'd0, cdone[1]}, 1);
        @(posedge clk);
        #1 creq[1] = 1'b0;
        @(negedge clk);
        #1;
        chk("R7 line now shared so store upgrades", {30'd0, bcmd[0]}, 32'd2);
        chk("R4 upgrade completes", {31'd0, cdone[0]}, 1);
        @(posedge clk);
        #1 creq[0] = 1'b0;
        shadow[8'h13] = 16'hBBBB;
        run_op(1, 1'b0, 8'h13, 16'h0, rd, n, c, pi);
        chk("R6 peer copy invalidated", {29'd0, c}, 32'd0);
        chk("R7 second supply", {31'd0, pi}, 1);
        chk("R7 coherent data", {16'd0, rd}, 32'hBBBB);

        // R10: two stores to a shared line; loser re-derives its command
        run_op(0, 1'b0, 8'h22, 16'h0, rd, n, c, pi);
        run_op(1, 1'b0, 8'h22, 16'h0, rd, n, c, pi);
        chk("R2 shared fill data", {16'd0, rd}, {16'd0, shadow[8'h22]});
        @(negedge clk);
        creq[0] = 1'b1; cwe[0] = 1'b1; caddr[0] = 8'h22; cwdata[0] = 16'hCCCC;
        creq[1] = 1'b1; cwe[1] = 1'b1; caddr[1] = 8'h22; cwdata[1] = 16'hDDDD;
        #1;
        chk("R4 winner upgrade", {30'd0, bcmd[0]}, 32'd2);
        chk("R4 winner done", {31'd0, cdone[0]}, 1);
        chk("R10 loser pending upgrade", {30'd0, bcmd[1]}, 32'd2);
        chk("R10 loser waits", {31'd0, cdone[1]}, 0);
        @(posedge clk);
        #1 creq[0] = 1'b0;
        @(negedge clk);
        #1;
        chk("R10 loser now read-exclusive", {30'd0, bcmd[1]}, 32'd1);
        chk("R8 winner intervenes", {31'd0, sint[0]}, 1);
        chk("R8 winner word", {16'd0, sdata[0]}, 32'hCCCC);
        chk("R10 loser done", {31'd0, cdone[1]}, 1);
        @(posedge clk);
        #1 creq[1] = 1'b0;
        shadow[8'h22] = 16'hDDDD;
        run_op(0, 1'b0, 8'h22, 16'h0, rd, n, c, pi);
        chk("R8 winner invalidated", {29'd0, c}, 32'd0);
        chk("R8 final data", {16'd0, rd}, 32'hDDDD);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule